// File: doc/BRIEF.md
# Configuration Write Sequencer with Mode Select

This block decodes a two-bit working-mode input. In its two write modes it loads one of two on-chip memories over a 12-bit data bus. The decision-tree memory holds 12-bit words, and each word goes in as a two-cycle write. The coefficient memory holds 60-bit words. Each coefficient word is built from five 12-bit bus transfers and then written in a sixth, commit cycle. In both memories the address counts up by itself.

The sequencer drives only the write side (port A) of each memory: address, data and write enable. The evaluation datapath reads the memories through their other port (port B), and that port is outside this block. The mode decode also gives one enable for normal evaluation and one for test capture.

The host keeps the mode at a write value for as long as the load runs. It presents a new bus value on each capture cycle. It sends no handshake, because the cycle pattern is fixed from the moment the mode is entered.

Top module: `cfg_loader`

## Requirements
- R1: Mode 2'b00 raises eval_en_o. Mode 2'b11 raises test_en_o. Modes 2'b01 and 2'b10 raise neither. In modes 2'b00 and 2'b11 neither write enable is ever high.
- R2: In mode 2'b01 each tree word takes two cycles. The first cycle captures data_i. In the second cycle tree_we_o is high and tree_data_o equals the captured value.
- R3: tree_addr_o is 0 on the first word after mode 2'b01 is entered. It rises by one after each tree write and wraps from 16383 to 0. A 32768-cycle stay in mode 2'b01 therefore yields 16384 writes and ends with the address back at 0.
- R4: In mode 2'b10 five consecutive cycles capture data_i. The first chunk goes to param_data_o[11:0], the second to [23:12], and so on up to the fifth in [59:48]. param_we_o is high only on the sixth cycle, and data_i in that cycle is ignored.
- R5: param_addr_o is 0 on the first word after mode 2'b10 is entered. It rises by one after each commit and wraps from 4095 to 0. A 24576-cycle stay yields 4096 writes and ends at address 0.
- R6: If the mode leaves a write mode in the middle of a word, the partial word is dropped. No write enable rises for it, the address returns to 0, and the next entry starts a fresh word.
- R7: tree_we_o and param_we_o are never high together.
- R8: After reset both write enables are low and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Working mode: 00 run, 01 tree load, 10 coefficient load, 11 test |
| data_i | input | 12 | Load data bus |
| eval_en_o | output | 1 | Normal evaluation enabled |
| test_en_o | output | 1 | Test capture enabled |
| tree_addr_o | output | 14 | Tree memory write address |
| tree_data_o | output | 12 | Tree memory write data |
| tree_we_o | output | 1 | Tree memory write enable |
| param_addr_o | output | 12 | Coefficient memory write address |
| param_data_o | output | 60 | Coefficient memory write data |
| param_we_o | output | 1 | Coefficient memory write enable |

## Verification
The assertions check on every cycle that:
- a write enable never stays high for two cycles in a row;
- each commit advances the address by exactly one;
- leaving a write mode clears the address and suppresses the next strobe;
- the two strobes are mutually exclusive;
- no strobe appears in run or test mode.

The other behaviours can only be shown by the bench's scenarios:
- that each chunk lands in its own field, in arrival order;
- that the commit-cycle bus value is ignored;
- that a resumed load rebuilds the whole word;
- that full fills wrap the addresses after exactly 16384 and 4096 words.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  localparam int unsigned CHUNK_W      = 12;
  localparam int unsigned TREE_AW      = 14;
  localparam int unsigned PARAM_AW     = 12;
  localparam int unsigned PARAM_CHUNKS = 5;

  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_TREE_WR  = 2'b01,
    MODE_PARAM_WR = 2'b10,
    MODE_TEST     = 2'b11
  } cfg_mode_e;
endpackage

// File: rtl/cfg_mode_decode.sv
`timescale 1ns/1ps
module cfg_mode_decode
  import cfg_loader_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       eval_en_o,
  output logic       test_en_o,
  output logic       tree_en_o,
  output logic       param_en_o
);
  always_comb begin
    eval_en_o  = 1'b0;
    test_en_o  = 1'b0;
    tree_en_o  = 1'b0;
    param_en_o = 1'b0;
    case (cfg_mode_e'(mode_i))
      MODE_RUN:      eval_en_o  = 1'b1;
      MODE_TREE_WR:  tree_en_o  = 1'b1;
      MODE_PARAM_WR: param_en_o = 1'b1;
      default:       test_en_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfg_word_writer.sv
`timescale 1ns/1ps
// Captures CHUNKS bus beats into one word, then strobes a write in the following cycle.
module cfg_word_writer #(
  parameter int unsigned CHUNK_W = 12,
  parameter int unsigned CHUNKS  = 1,
  parameter int unsigned ADDR_W  = 14,
  localparam int unsigned WORD_W = CHUNK_W * CHUNKS,
  localparam int unsigned CNT_W  = $clog2(CHUNKS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               we_o
);
  localparam logic [CNT_W-1:0] LastPhase = CNT_W'(CHUNKS);

  logic [CNT_W-1:0]   phase_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CHUNK_W-1:0] chunk_q [CHUNKS];
  logic               commit;

  assign commit = en_i && (phase_q == LastPhase);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      addr_q  <= '0;
    end else if (!en_i) begin
      phase_q <= '0;
      addr_q  <= '0;
    end else if (commit) begin
      phase_q <= '0;
      addr_q  <= addr_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chunk_q[g] <= '0;
      else if (en_i && phase_q == CNT_W'(g)) chunk_q[g] <= chunk_i;
    end
    assign word_o[g*CHUNK_W +: CHUNK_W] = chunk_q[g];
  end

  assign addr_o = addr_q;
  assign we_o   = commit;

  // R2 / R4: a strobe is always followed by a capture cycle
  a_r2_we_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R3 / R5: each commit advances the address by one
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> addr_o == $past(addr_o) + 1'b1);
  // R6: exit clears address and drops the pending word
  a_r6_exit_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> addr_o == '0);
  a_r6_exit_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !we_o);
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
  import cfg_loader_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [1:0]                          mode_i,
  input  logic [CHUNK_W-1:0]                  data_i,
  output logic                                eval_en_o,
  output logic                                test_en_o,
  output logic [TREE_AW-1:0]                  tree_addr_o,
  output logic [CHUNK_W-1:0]                  tree_data_o,
  output logic                                tree_we_o,
  output logic [PARAM_AW-1:0]                 param_addr_o,
  output logic [CHUNK_W*PARAM_CHUNKS-1:0]     param_data_o,
  output logic                                param_we_o
);
  logic tree_en, param_en;

  cfg_mode_decode u_decode (
    .mode_i     (mode_i),
    .eval_en_o  (eval_en_o),
    .test_en_o  (test_en_o),
    .tree_en_o  (tree_en),
    .param_en_o (param_en)
  );

  cfg_word_writer #(
    .CHUNK_W (CHUNK_W),
    .CHUNKS  (1),
    .ADDR_W  (TREE_AW)
  ) u_tree_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tree_en),
    .chunk_i (data_i),
    .addr_o  (tree_addr_o),
    .word_o  (tree_data_o),
    .we_o    (tree_we_o)
  );

  cfg_word_writer #(
    .CHUNK_W (CHUNK_W),
    .CHUNKS  (PARAM_CHUNKS),
    .ADDR_W  (PARAM_AW)
  ) u_param_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (param_en),
    .chunk_i (data_i),
    .addr_o  (param_addr_o),
    .word_o  (param_data_o),
    .we_o    (param_we_o)
  );

  // R7: one memory written at a time
  a_r7_single_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tree_we_o, param_we_o}));
  // R1: run and test modes never write
  a_r1_no_we_outside_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_en_o || test_en_o) |-> !(tree_we_o || param_we_o));
endmodule

// File: tb/cfg_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [11:0] data_i = '0;
  logic        eval_en_o, test_en_o, tree_we_o, param_we_o;
  logic [13:0] tree_addr_o;
  logic [11:0] tree_data_o, param_addr_o;
  logic [59:0] param_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cfg_loader dut_i (
    .clk_i, .rst_ni, .mode_i, .data_i, .eval_en_o, .test_en_o,
    .tree_addr_o, .tree_data_o, .tree_we_o,
    .param_addr_o, .param_data_o, .param_we_o
  );

  localparam int NV = 4;
  localparam logic [11:0] VEC [NV][5] = '{
    '{12'h001, 12'h023, 12'h456, 12'h789, 12'hABC},
    '{12'hFFF, 12'h000, 12'hFFF, 12'h000, 12'hFFF},
    '{12'h5A5, 12'hA5A, 12'h3C3, 12'hC3C, 12'h7E7},
    '{12'h100, 12'h200, 12'h400, 12'h800, 12'h0F0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge with mode already decided; returns at the negedge after the commit.
  task automatic tree_word(input logic [11:0] d, input logic [13:0] a);
    mode_i = 2'b01;
    data_i = d;
    chk(!tree_we_o, "R2 idle-before-capture", 64'(tree_we_o), 0);
    @(negedge clk_i);
    data_i = ~d;
    chk(tree_we_o, "R2 we", 64'(tree_we_o), 1);
    chk(tree_data_o == d, "R2 data", 64'(tree_data_o), 64'(d));
    chk(tree_addr_o == a, "R3 addr", 64'(tree_addr_o), 64'(a));
    @(negedge clk_i);
  endtask

  task automatic param_word(input int v, input logic [11:0] a);
    logic [59:0] exp;
    mode_i = 2'b10;
    exp = {VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]};
    for (int i = 0; i < 5; i++) begin
      data_i = VEC[v][i];
      if (param_we_o) chk(1'b0, "R4 early we", 1, 0);
      @(negedge clk_i);
    end
    data_i = 12'hDEA;  // ignored on commit cycle
    chk(param_we_o, "R4 we sixth", 64'(param_we_o), 1);
    chk(param_data_o == exp, "R4 fields", 64'(param_data_o), 64'(exp));
    chk(param_addr_o == a, "R5 addr", 64'(param_addr_o), 64'(a));
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(!tree_we_o && !param_we_o, "R8 we", {tree_we_o, param_we_o}, 0);
    chk(tree_addr_o == 0 && param_addr_o == 0, "R8 addr", {tree_addr_o, param_addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 decode
    mode_i = 2'b00; #1;
    chk(eval_en_o && !test_en_o, "R1 run", {eval_en_o, test_en_o}, 2'b10);
    mode_i = 2'b11; #1;
    chk(test_en_o && !eval_en_o, "R1 test", {eval_en_o, test_en_o}, 2'b01);
    mode_i = 2'b01; #1;
    chk(!test_en_o && !eval_en_o, "R1 tree", {eval_en_o, test_en_o}, 0);
    mode_i = 2'b11;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (tree_we_o || param_we_o) cnt++;
    end
    chk(cnt == 0, "R1 no writes in test", cnt, 0);

    // Table: tree then coefficient words
    for (int v = 0; v < NV; v++) tree_word(VEC[v][0], 14'(v));
    for (int v = 0; v < NV; v++) param_word(v, 12'(v));
    chk(param_data_o[59:48] == VEC[NV-1][4], "R4 commit data ignored",
        64'(param_data_o[59:48]), 64'(VEC[NV-1][4]));

    // R6: abort coefficient word after three chunks
    mode_i = 2'b00;
    @(negedge clk_i);
    mode_i = 2'b10;
    for (int i = 0; i < 3; i++) begin data_i = 12'h111; @(negedge clk_i); end
    mode_i = 2'b00;
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (param_we_o) cnt++;
    end
    chk(cnt == 0, "R6 param no write", cnt, 0);
    chk(param_addr_o == 0, "R6 param addr", 64'(param_addr_o), 0);
    param_word(2, 12'd0);

    // R6: abort tree word on its strobe cycle
    mode_i = 2'b01; data_i = 12'h321;
    @(negedge clk_i);
    mode_i = 2'b00; #1;
    chk(!tree_we_o, "R6 tree strobe dropped", 64'(tree_we_o), 0);
    @(negedge clk_i);
    chk(tree_addr_o == 0, "R6 tree addr", 64'(tree_addr_o), 0);
    tree_word(12'h654, 14'd0);

    // R3 full tree fill
    mode_i = 2'b00;
    @(negedge clk_i);
    mode_i = 2'b01; cnt = 0;
    for (int i = 0; i < 32768; i++) begin
      data_i = 12'(i);
      @(negedge clk_i);
      if (tree_we_o) cnt++;
    end
    chk(cnt == 16384, "R3 fill count", cnt, 16384);
    chk(tree_addr_o == 0, "R3 wrap", 64'(tree_addr_o), 0);

    // R5 full coefficient fill
    mode_i = 2'b00;
    @(negedge clk_i);
    mode_i = 2'b10; cnt = 0;
    for (int i = 0; i < 24576; i++) begin
      data_i = 12'(i);
      @(negedge clk_i);
      if (param_we_o) cnt++;
      if (param_we_o && tree_we_o) chk(1'b0, "R7 both strobes", 1, 0);
    end
    chk(cnt == 4096, "R5 fill count", cnt, 4096);
    chk(param_addr_o == 0, "R5 wrap", 64'(param_addr_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule